// File: doc/BRIEF.md
# Breaking-Event Address Recorder

This block remembers where the instruction stream last left its sequential path. Each cycle the retire stage reports the address of the instruction it is retiring and whether that instruction was a taken branch. If the branch was run indirectly, as the target of an execute-type instruction, the retire stage also raises a flag and supplies the execute instruction's address. The block keeps a 64-bit register, the last-break address. On every taken branch it loads that register with the address of the redirecting instruction, never the branch target. For an indirect branch it loads the execute instruction's address instead.

When an interrupt pulse arrives, the block writes a copy of the register to storage. It does this through a one-beat store port with valid/ready handshaking, and the store always goes to real address 0x110, which is decimal 272. Once `st_valid` rises, `st_addr` and `st_data` stay fixed until the cycle in which `st_ready` is sampled high. That cycle completes the transfer, and the port then goes idle. No transfer is queued: an interrupt pulse that arrives while a store is outstanding is dropped. The current register value can be read at any time on `rd_bear`.

Top module: `brk_evt_rec`

## Requirements
- R1: After reset the last-break register reads 0 and `st_valid` is low.
- R2: When a retire cycle has `ret_valid`=1, `ret_taken`=1 and `ret_via_exec`=0, `rd_bear` shows that cycle's `ret_pc` from the next clock edge on.
- R3: A retire cycle with `ret_taken`=0 leaves `rd_bear` unchanged. So does any cycle with `ret_valid`=0, whatever `ret_taken` says.
- R4: When a retire cycle has `ret_valid`=1, `ret_taken`=1 and `ret_via_exec`=1, `rd_bear` takes `exec_pc` and not `ret_pc`.
- R5: If `irq` is high while no store is outstanding, `st_valid` is high after the next edge. In that case `st_addr` equals 0x110 and `st_data` equals the register value from the cycle in which `irq` was sampled.
- R6: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr` and `st_data` keep their values.
- R7: An `irq` pulse is ignored while a store is outstanding, and this includes the cycle in which the handshake completes. Such a pulse starts no second store, and `st_valid` is low after the completing edge.
- R8: If `irq` and a taken branch are sampled in the same cycle, the store carries the register value from before the branch. The register itself still takes the branch update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 64 | Address of the retiring instruction |
| ret_taken | input | 1 | The retiring instruction redirected the flow |
| ret_via_exec | input | 1 | The retiring instruction was run as the target of an execute-type instruction |
| exec_pc | input | 64 | Address of that execute-type instruction |
| irq | input | 1 | Interrupt pulse requesting a dump of the register |
| st_valid | output | 1 | Store beat is offered |
| st_ready | input | 1 | Storage accepts the beat |
| st_addr | output | 64 | Store real address, 0x110 |
| st_data | output | 64 | Stored doubleword |
| rd_bear | output | 64 | Current last-break address |

## Verification
Two functions can fall in the same cycle: an interrupt being accepted and a taken branch updating the register. The test provokes this by raising `irq` together with a taken retire of a fresh address. It then checks that the offered doubleword holds the earlier address while `rd_bear` already shows the new one. A second overlap also gets its own test. In that test an interrupt pulse lands on the very cycle in which the pending store completes its handshake, and the test checks that the pulse is dropped.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned DEF_AW = 64;
  localparam logic [63:0] DEF_DUMP_ADDR = 64'h0000_0000_0000_0110;
  typedef enum logic {DS_IDLE = 1'b0, DS_SEND = 1'b1} dump_st_e;
endpackage

// File: rtl/brk_capture.sv
module brk_capture #(
  parameter int unsigned AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic          ret_taken,
  input  logic          ret_via_exec,
  input  logic [AW-1:0] exec_pc,
  output logic [AW-1:0] bear
);
  logic          upd;
  logic [AW-1:0] src;

  assign upd = ret_valid & ret_taken;
  assign src = ret_via_exec ? exec_pc : ret_pc;

  always_ff @(posedge clk) begin
    if (!rst_n)   bear <= '0;
    else if (upd) bear <= src;
  end

  a_r2_direct_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_taken && !ret_via_exec) |=> bear == $past(ret_pc));
  a_r4_exec_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_taken && ret_via_exec) |=> bear == $past(exec_pc));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_valid && ret_taken) |=> $stable(bear));
endmodule

// File: rtl/brk_dump.sv
module brk_dump
  import brk_pkg::*;
#(
  parameter int unsigned AW = 64,
  parameter logic [AW-1:0] DUMP_ADDR = DEF_DUMP_ADDR[AW-1:0]
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [AW-1:0] snap_in,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [AW-1:0] st_addr,
  output logic [AW-1:0] st_data
);
  dump_st_e      state;
  logic [AW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= DS_IDLE;
      hold_q <= '0;
    end else begin
      case (state)
        DS_IDLE: if (irq) begin
          state  <= DS_SEND;
          hold_q <= snap_in;
        end
        DS_SEND: if (st_ready) state <= DS_IDLE;
        default: state <= DS_IDLE;
      endcase
    end
  end

  assign st_valid = (state == DS_SEND);
  assign st_addr  = DUMP_ADDR;
  assign st_data  = hold_q;

  a_r5_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && irq) |=> (st_valid && st_data == $past(snap_in)));
  a_r6_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_addr)));
  a_r7_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !st_valid);
endmodule

// File: rtl/brk_evt_rec.sv
module brk_evt_rec
  import brk_pkg::*;
#(
  parameter int unsigned AW = DEF_AW,
  parameter logic [AW-1:0] DUMP_ADDR = DEF_DUMP_ADDR[AW-1:0]
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic          ret_taken,
  input  logic          ret_via_exec,
  input  logic [AW-1:0] exec_pc,
  input  logic          irq,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [AW-1:0] st_addr,
  output logic [AW-1:0] st_data,
  output logic [AW-1:0] rd_bear
);
  logic [AW-1:0] bear;

  brk_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_taken(ret_taken), .ret_via_exec(ret_via_exec), .exec_pc(exec_pc),
    .bear(bear)
  );

  brk_dump #(.AW(AW), .DUMP_ADDR(DUMP_ADDR)) u_dump (
    .clk(clk), .rst_n(rst_n), .irq(irq), .snap_in(bear),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data)
  );

  assign rd_bear = bear;

  a_r8_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && irq && ret_valid && ret_taken) |=> st_data == $past(rd_bear));
endmodule

// File: tb/sim_brk_evt_rec.sv
`timescale 1ns/1ps
module sim_brk_evt_rec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0, ret_taken = 1'b0, ret_via_exec = 1'b0;
  logic [63:0] ret_pc = '0, exec_pc = '0;
  logic        irq = 1'b0, st_ready = 1'b0;
  logic        st_valid;
  logic [63:0] st_addr, st_data, rd_bear;

  int total = 0;
  int bad = 0;
  int hs_cnt = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  brk_evt_rec u0 (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_taken(ret_taken), .ret_via_exec(ret_via_exec), .exec_pc(exec_pc),
    .irq(irq), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .rd_bear(rd_bear)
  );

  always @(posedge clk) begin
    if (rst_n && st_valid && st_ready) hs_cnt <= hs_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<5000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic retire(input logic v, input logic tk, input logic vx,
                        input logic [63:0] pc, input logic [63:0] xpc);
    ret_valid = v; ret_taken = tk; ret_via_exec = vx; ret_pc = pc; exec_pc = xpc;
    step();
    ret_valid = 0; ret_taken = 0; ret_via_exec = 0;
  endtask

  task automatic t_reset();
    step(); step();
    chk(rd_bear == 64'h0, "R1 bear", rd_bear, 64'h0);
    chk(st_valid == 1'b0, "R1 st_valid", {63'b0, st_valid}, 64'h0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_direct();
    retire(1, 1, 0, 64'h0000_0000_0000_4000, 64'hDEAD);
    chk(rd_bear == 64'h4000, "R2 first", rd_bear, 64'h4000);
    retire(1, 1, 0, 64'hFFFF_0000_1234_5678, 64'h0);
    chk(rd_bear == 64'hFFFF_0000_1234_5678, "R2 second", rd_bear, 64'hFFFF_0000_1234_5678);
  endtask

  task automatic t_hold();
    retire(1, 0, 0, 64'h9999, 64'h0);
    chk(rd_bear == 64'hFFFF_0000_1234_5678, "R3 not-taken", rd_bear, 64'hFFFF_0000_1234_5678);
    retire(0, 1, 1, 64'h7777, 64'h8888);
    chk(rd_bear == 64'hFFFF_0000_1234_5678, "R3 no-valid", rd_bear, 64'hFFFF_0000_1234_5678);
  endtask

  task automatic t_exec();
    retire(1, 1, 1, 64'h0000_0000_0000_A000, 64'h0000_0000_0000_B008);
    chk(rd_bear == 64'hB008, "R4 exec addr", rd_bear, 64'hB008);
  endtask

  task automatic t_dump();
    int base;
    base = hs_cnt;
    st_ready = 0;
    irq = 1; step(); irq = 0;
    chk(st_valid == 1'b1, "R5 valid", {63'b0, st_valid}, 64'h1);
    chk(st_addr == 64'h110, "R5 addr", st_addr, 64'h110);
    chk(st_data == 64'hB008, "R5 data", st_data, 64'hB008);
    irq = 1; step(); irq = 0;
    retire(1, 1, 0, 64'h5550, 64'h0);
    step();
    chk(st_valid == 1'b1, "R6 still valid", {63'b0, st_valid}, 64'h1);
    chk(st_data == 64'hB008, "R6 data stable", st_data, 64'hB008);
    chk(st_addr == 64'h110, "R6 addr stable", st_addr, 64'h110);
    st_ready = 1; irq = 1; step(); st_ready = 0; irq = 0;
    chk(st_valid == 1'b0, "R7 idle after done", {63'b0, st_valid}, 64'h0);
    step(); step();
    chk(st_valid == 1'b0, "R7 no relaunch", {63'b0, st_valid}, 64'h0);
    chk(hs_cnt == base + 1, "R7 one store", 64'(hs_cnt - base), 64'h1);
  endtask

  task automatic t_same();
    irq = 1;
    ret_valid = 1; ret_taken = 1; ret_via_exec = 0; ret_pc = 64'hC0DE_0000;
    step();
    irq = 0; ret_valid = 0; ret_taken = 0;
    chk(st_data == 64'h5550, "R8 old stored", st_data, 64'h5550);
    chk(rd_bear == 64'hC0DE_0000, "R8 reg updated", rd_bear, 64'hC0DE_0000);
    st_ready = 1; step(); st_ready = 0;
    chk(st_valid == 1'b0, "R8 store done", {63'b0, st_valid}, 64'h0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_hold();
    t_exec();
    t_dump();
    t_same();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule